// File: doc/BRIEF.md
# Dual-Organisation Read-Only Memory Port

This block models the read side of a one-time-programmable memory that can present itself either as a 16-bit-wide device or as an 8-bit-wide device. A word address picks a 16-bit storage word. An organisation-select input chooses how that word leaves the block. In wide organisation all sixteen data lines are driven. In narrow organisation only the low eight lines are driven, and an extra low-order address bit picks which half of the word appears on them. On the physical device that bit shares a pin with data line 15. Here it is a separate input, and line 15 is simply left undriven.

Two active-low controls gate the outputs. The chip enable is the power-level select, and with it high the port is idle whatever the other controls do. The output enable gates the data lines for a selected device. Data is driven only when both are low. An identification flag stands in for the raised voltage that the device uses on one address line. While the flag is set, array contents are replaced by a fixed pair of identity bytes, and the lowest address bit chooses between them.

Storage is a parameterised array of flops loaded with known contents at reset. A programming strobe can only clear bits of the addressed word. Outputs are registered, so a result appears one clock after its inputs are sampled. Every data line has its own drive-enable output, which lets a bench observe high-impedance behaviour directly.

Top module: `drp_rom_port`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `data_out` and `data_oe` are all zeros.
- R2: With `chip_en_n`=0, `out_en_n`=0, `id_mode`=0 and `wide_sel`=1, the clock after sampling gives `data_oe`=16'hFFFF and `data_out` equal to the stored word at `word_addr`.
- R3: With both enables low, `id_mode`=0 and `wide_sel`=0, the next clock gives `data_oe`=16'h00FF. `data_out[7:0]` is stored bits 7:0 when `ext_addr_bit`=0 and stored bits 15:8 when `ext_addr_bit`=1.
- R4: With `chip_en_n`=1, the next clock gives `data_oe`=0 regardless of `out_en_n`, `wide_sel` and `id_mode`.
- R5: With `chip_en_n`=0 and `out_en_n`=1, the next clock gives `data_oe`=0.
- R6: With both enables low and `id_mode`=1, `data_out[7:0]` is 8'h20 when `word_addr[0]`=0 and 8'h32 when `word_addr[0]`=1, and `data_out[15:8]` is 0. All other address bits are ignored. `data_oe` is 16'hFFFF when `wide_sel`=1 and 16'h00FF when `wide_sel`=0.
- R7: After reset, word i holds {i[7:0] ^ 8'h5A, i[7:0]} for i < PRELOAD_WORDS and 16'hFFFF for every higher address.
- R8: A clock edge with `prog_en`=1, `chip_en_n`=0 and `out_en_n`=1 replaces the word at `word_addr` by its bitwise AND with `prog_data`. A bit that reads 0 never returns to 1.
- R9: `prog_en` changes no stored word unless `chip_en_n`=0 and `out_en_n`=1.
- R10: Any `data_out` bit whose `data_oe` bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the array contents |
| word_addr | input | AW | Word address |
| ext_addr_bit | input | 1 | Half-word select in narrow organisation |
| chip_en_n | input | 1 | Active-low device select |
| out_en_n | input | 1 | Active-low output gate |
| wide_sel | input | 1 | 1 = 16-bit organisation, 0 = 8-bit organisation |
| id_mode | input | 1 | Identification readout instead of array data |
| prog_en | input | 1 | Programming strobe |
| prog_data | input | 2*BYTE_W | Word to AND into the addressed location |
| data_out | output | 2*BYTE_W | Registered data lines |
| data_oe | output | 2*BYTE_W | Per-line drive enables, 1 = driven |

## Verification
The bench builds the block with AW=6 and PRELOAD_WORDS=16. This gives 64 words, of which 16 hold a pattern and 48 are blank. With that split, both preloaded and blank words can be read, including the words either side of the boundary at 15 and 16. Because every preloaded word has distinct upper and lower bytes, a swapped or stuck byte lane shows up at once. The spare blank words give room for repeated programming of one location, which shows that bits only ever clear.

// File: rtl/drp_pkg.sv
package drp_pkg;

   typedef enum logic [2:0] {
      M_STANDBY = 3'd0,
      M_QUIET   = 3'd1,
      M_WORD    = 3'd2,
      M_BYTE    = 3'd3,
      M_ID_WORD = 3'd4,
      M_ID_BYTE = 3'd5
   } drp_mode_e;

   localparam logic [7:0] MFR_ID      = 8'h20;
   localparam logic [7:0] DEV_ID      = 8'h32;
   localparam logic [7:0] PRELOAD_XOR = 8'h5A;

endpackage

// File: rtl/drp_mode_decode.sv
module drp_mode_decode
   import drp_pkg::*;
(
   input  logic      chip_en_n,
   input  logic      out_en_n,
   input  logic      wide_sel,
   input  logic      id_mode,
   input  logic      prog_en,
   output drp_mode_e mode,
   output logic      wr_en
);

   always_comb begin
      if (chip_en_n)
         mode = M_STANDBY;
      else if (out_en_n)
         mode = M_QUIET;
      else if (id_mode)
         mode = wide_sel ? M_ID_WORD : M_ID_BYTE;
      else
         mode = wide_sel ? M_WORD : M_BYTE;
   end

   // programming only with the device selected and its outputs gated off
   assign wr_en = prog_en & ~chip_en_n & out_en_n;

endmodule

// File: rtl/drp_store.sv
module drp_store
   import drp_pkg::*;
#(
   parameter int AW            = 6,
   parameter int BYTE_W        = 8,
   parameter int PRELOAD_WORDS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       rd_addr,
   input  logic                wr_en,
   input  logic [AW-1:0]       wr_addr,
   input  logic [2*BYTE_W-1:0] wr_data,
   output logic [2*BYTE_W-1:0] rd_word
);

   localparam int DW    = 2 * BYTE_W;
   localparam int DEPTH = 1 << AW;

   logic [DEPTH-1:0][DW-1:0] words;
   logic [DW-1:0]            prior_word;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      localparam logic [BYTE_W-1:0] IDX   = BYTE_W'(i);
      localparam logic [DW-1:0]     START = (i < PRELOAD_WORDS) ?
         {IDX ^ BYTE_W'(PRELOAD_XOR), IDX} : {DW{1'b1}};
      logic [DW-1:0] cell_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= START;
         else if (wr_en && (wr_addr == AW'(i)))
            cell_q <= cell_q & wr_data;
      end

      assign words[i] = cell_q;
   end

   assign rd_word    = words[rd_addr];
   assign prior_word = words[wr_addr];

   // R8: a programmed word gains no new ones
   p_clear_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((words[$past(wr_addr)] & ~$past(prior_word)) == '0));

   // R9: without a write strobe the whole array holds
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (words == $past(words)));

endmodule

// File: rtl/drp_lane_sel.sv
module drp_lane_sel
   import drp_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  drp_mode_e           mode,
   input  logic [2*BYTE_W-1:0] word,
   input  logic                hi_lane,
   input  logic                code_sel,
   output logic [2*BYTE_W-1:0] nxt_data,
   output logic [2*BYTE_W-1:0] nxt_oe
);

   localparam int DW    = 2 * BYTE_W;
   localparam int LANES = 2;

   logic [LANES-1:0][BYTE_W-1:0] lane_val;
   logic [BYTE_W-1:0]            id_val;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_val[l] = word[l*BYTE_W +: BYTE_W];
   end

   assign id_val = code_sel ? BYTE_W'(DEV_ID) : BYTE_W'(MFR_ID);

   always_comb begin
      nxt_data = '0;
      nxt_oe   = '0;
      case (mode)
         M_WORD: begin
            nxt_data = word;
            nxt_oe   = {DW{1'b1}};
         end
         M_BYTE: begin
            nxt_data[BYTE_W-1:0] = lane_val[hi_lane];
            nxt_oe[BYTE_W-1:0]   = {BYTE_W{1'b1}};
         end
         M_ID_WORD: begin
            nxt_data[BYTE_W-1:0] = id_val;
            nxt_oe               = {DW{1'b1}};
         end
         M_ID_BYTE: begin
            nxt_data[BYTE_W-1:0] = id_val;
            nxt_oe[BYTE_W-1:0]   = {BYTE_W{1'b1}};
         end
         default: begin
            nxt_data = '0;
            nxt_oe   = '0;
         end
      endcase
   end

endmodule

// File: rtl/drp_rom_port.sv
module drp_rom_port
   import drp_pkg::*;
#(
   parameter int AW            = 6,
   parameter int BYTE_W        = 8,
   parameter int PRELOAD_WORDS = 2 ** (AW - 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       word_addr,
   input  logic                ext_addr_bit,
   input  logic                chip_en_n,
   input  logic                out_en_n,
   input  logic                wide_sel,
   input  logic                id_mode,
   input  logic                prog_en,
   input  logic [2*BYTE_W-1:0] prog_data,
   output logic [2*BYTE_W-1:0] data_out,
   output logic [2*BYTE_W-1:0] data_oe
);

   localparam int DW    = 2 * BYTE_W;
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("drp_rom_port: AW must lie in 1..10");
   end
   if (BYTE_W < 8) begin : g_bad_bw
      $error("drp_rom_port: BYTE_W must be at least 8");
   end
   if (PRELOAD_WORDS < 0 || PRELOAD_WORDS > DEPTH) begin : g_bad_pre
      $error("drp_rom_port: PRELOAD_WORDS exceeds depth");
   end

   drp_mode_e     mode;
   logic          wr_en;
   logic [DW-1:0] rd_word;
   logic [DW-1:0] nxt_data;
   logic [DW-1:0] nxt_oe;

   drp_mode_decode u_dec (
      .chip_en_n (chip_en_n),
      .out_en_n  (out_en_n),
      .wide_sel  (wide_sel),
      .id_mode   (id_mode),
      .prog_en   (prog_en),
      .mode      (mode),
      .wr_en     (wr_en)
   );

   drp_store #(
      .AW            (AW),
      .BYTE_W        (BYTE_W),
      .PRELOAD_WORDS (PRELOAD_WORDS)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (word_addr),
      .wr_en   (wr_en),
      .wr_addr (word_addr),
      .wr_data (prog_data),
      .rd_word (rd_word)
   );

   drp_lane_sel #(
      .BYTE_W (BYTE_W)
   ) u_lane (
      .mode     (mode),
      .word     (rd_word),
      .hi_lane  (ext_addr_bit),
      .code_sel (word_addr[0]),
      .nxt_data (nxt_data),
      .nxt_oe   (nxt_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out <= '0;
         data_oe  <= '0;
      end else begin
         data_out <= nxt_data;
         data_oe  <= nxt_oe;
      end
   end

   p_word_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!chip_en_n && !out_en_n && !id_mode && wide_sel)
      |-> (data_oe == {DW{1'b1}}));

   p_word_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!chip_en_n && !out_en_n && !id_mode && wide_sel)
      |-> (data_out == $past(rd_word)));

   p_byte_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!chip_en_n && !out_en_n && !id_mode && !wide_sel)
      |-> (data_oe == DW'({BYTE_W{1'b1}})));

   p_standby_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(chip_en_n) |-> (data_oe == '0));

   p_gate_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!chip_en_n && out_en_n) |-> (data_oe == '0));

   p_id_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!chip_en_n && !out_en_n && id_mode)
      |-> (data_out[DW-1:BYTE_W] == '0 &&
           data_out[BYTE_W-1:0] == ($past(word_addr[0]) ?
              BYTE_W'(DEV_ID) : BYTE_W'(MFR_ID))));

   p_undriven_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((data_out & ~data_oe) == '0));

endmodule

// File: tb/drp_rom_port_tb_top.sv
module drp_rom_port_tb_top;

   localparam int AW   = 6;
   localparam int BW   = 8;
   localparam int DW   = 16;
   localparam int PRE  = 16;
   localparam int NW   = 1 << AW;

   typedef struct {
      int          due;
      logic [15:0] data;
      logic [15:0] oe;
      string       req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] word_addr = '0;
   logic          ext_addr_bit = 1'b0;
   logic          chip_en_n = 1'b1;
   logic          out_en_n = 1'b1;
   logic          wide_sel = 1'b1;
   logic          id_mode = 1'b0;
   logic          prog_en = 1'b0;
   logic [DW-1:0] prog_data = '0;
   logic [DW-1:0] data_out;
   logic [DW-1:0] data_oe;

   int   checks = 0;
   int   failures = 0;
   int   cyc = 0;
   bit   done = 0;
   exp_t sb[$];
   logic [15:0] model_mem [NW];

   always #4 clk = ~clk;

   drp_rom_port #(.AW(AW), .BYTE_W(BW), .PRELOAD_WORDS(PRE)) dut_i (
      .clk (clk), .rst_n (rst_n), .word_addr (word_addr),
      .ext_addr_bit (ext_addr_bit), .chip_en_n (chip_en_n),
      .out_en_n (out_en_n), .wide_sel (wide_sel), .id_mode (id_mode),
      .prog_en (prog_en), .prog_data (prog_data),
      .data_out (data_out), .data_oe (data_oe)
   );

   // monitor: compares items due in this cycle
   always @(negedge clk) begin
      cyc++;
      while (sb.size() > 0 && sb[0].due == cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (data_out !== e.data || data_oe !== e.oe) begin
            failures++;
            $display("FAIL %s: data=%h oe=%h expected data=%h oe=%h",
                     e.req, data_out, data_oe, e.data, e.oe);
         end
      end
   end

   task automatic step(input logic ce_n, input logic oe_n, input logic wide,
                       input logic id, input logic ext, input logic [AW-1:0] a,
                       input logic pg, input logic [15:0] pd, input string req);
      exp_t e;
      logic [15:0] w;
      @(negedge clk);
      #1;
      chip_en_n = ce_n; out_en_n = oe_n; wide_sel = wide; id_mode = id;
      ext_addr_bit = ext; word_addr = a; prog_en = pg; prog_data = pd;
      e.due = cyc + 1; e.req = req; e.data = '0; e.oe = '0;
      if (!ce_n && !oe_n) begin
         if (id) begin
            e.data = {8'h00, (a[0] ? 8'h32 : 8'h20)};
            e.oe   = wide ? 16'hFFFF : 16'h00FF;
         end else begin
            w = model_mem[a];
            if (wide) begin
               e.data = w; e.oe = 16'hFFFF;
            end else begin
               e.data = {8'h00, (ext ? w[15:8] : w[7:0])};
               e.oe   = 16'h00FF;
            end
         end
      end
      sb.push_back(e);
      if (pg && !ce_n && oe_n) model_mem[a] = model_mem[a] & pd;  // R8/R9
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NW; i++)
         model_mem[i] = (i < PRE) ? {8'(i) ^ 8'h5A, 8'(i)} : 16'hFFFF;  // R7
      repeat (3) @(negedge clk);
      checks++;  // R1 during reset
      if (data_out !== '0 || data_oe !== '0) begin
         failures++;
         $display("FAIL R1: data=%h oe=%h expected data=0000 oe=0000", data_out, data_oe);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;  // R1 first edge after reset
      if (data_out !== '0 || data_oe !== '0) begin
         failures++;
         $display("FAIL R1: data=%h oe=%h expected data=0000 oe=0000", data_out, data_oe);
      end
      // R2 / R7 wide reads, preloaded and blank, either side of the boundary
      step(0, 0, 1, 0, 0, 6'd5,  0, 16'h0, "R2");
      step(0, 0, 1, 0, 0, 6'd0,  0, 16'h0, "R7");
      step(0, 0, 1, 0, 0, 6'd15, 0, 16'h0, "R7");
      step(0, 0, 1, 0, 0, 6'd16, 0, 16'h0, "R7");
      step(0, 0, 1, 0, 0, 6'd63, 0, 16'h0, "R7");
      // R3 / R10 narrow reads, both halves
      step(0, 0, 0, 0, 0, 6'd5,  0, 16'h0, "R3");
      step(0, 0, 0, 0, 1, 6'd5,  0, 16'h0, "R3");
      step(0, 0, 0, 0, 1, 6'd14, 0, 16'h0, "R10");
      // R4 standby dominates every other control
      step(1, 0, 1, 0, 0, 6'd5, 0, 16'h0, "R4");
      step(1, 0, 0, 1, 1, 6'd1, 0, 16'h0, "R4");
      // R5 output gate
      step(0, 1, 1, 0, 0, 6'd5, 0, 16'h0, "R5");
      // R6 identification readout
      step(0, 0, 1, 1, 0, 6'd0,         0, 16'h0, "R6");
      step(0, 0, 1, 1, 0, 6'b101011,    0, 16'h0, "R6");
      step(0, 0, 0, 1, 1, 6'b110100,    0, 16'h0, "R6");
      step(0, 0, 0, 1, 0, 6'b000001,    0, 16'h0, "R6");
      // R8 programming clears bits only
      step(0, 1, 1, 0, 0, 6'd20, 1, 16'h0F0F, "R8");
      step(0, 0, 1, 0, 0, 6'd20, 0, 16'h0,    "R8");
      step(0, 1, 1, 0, 0, 6'd20, 1, 16'hFFFF, "R8");
      step(0, 0, 1, 0, 0, 6'd20, 0, 16'h0,    "R8");
      step(0, 1, 1, 0, 0, 6'd20, 1, 16'h00FF, "R8");
      step(0, 0, 1, 0, 0, 6'd20, 0, 16'h0,    "R8");
      step(0, 0, 0, 0, 1, 6'd20, 0, 16'h0,    "R8");
      // R9 strobe without the write conditions leaves contents alone
      step(1, 1, 1, 0, 0, 6'd5, 1, 16'h0000, "R9");
      step(0, 0, 1, 0, 0, 6'd5, 1, 16'h0000, "R9");
      step(0, 0, 1, 0, 0, 6'd5, 0, 16'h0,    "R9");
      step(1, 0, 1, 0, 0, 6'd5, 0, 16'h0,    "R4");
      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         checks++;
         failures++;
         $display("FAIL scoreboard: pending=%0d expected=0", sb.size());
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule